// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Arbitration

This block is a 4096-word memory with two independent access ports, called left and right. Either port may read or write any word. Each port has its own 12-bit address, write data, read data and three active-low controls: chip enable, write select and output enable. Each bidirectional data bus is split into a read-data output, a read-data drive flag and a write-data input. The word width is a parameter and is meant to be set to 8 or 9 bits.

When both ports are enabled on the same address in the same cycle, an arbiter chooses one winner and raises a busy flag toward the other port. That port's write is dropped for the cycle. A port that already held the address keeps it. If both ports arrive together, the left port wins.

A mode input selects master or slave operation. A master uses its own arbiter and drives its busy flags out. A slave ignores its own arbiter and takes the busy flags from a master. Several blocks can therefore be placed side by side to widen the word, and all of them follow one arbitration decision. Reads have one cycle of latency. A read of a word that the other port writes in the same cycle returns the old value, and the new value can be read one cycle later.

Top module: `dpram_arb`

## Requirements
- R1: The array holds 2^12 words of DW bits (DW parameter, 8 or 9). A word written through one port reads back unchanged through either port.
- R2: Per-port decode. With chip enable high, the port does nothing and drives nothing. With chip enable low and write select low, the port writes, whatever output enable is. With chip enable low, write select high and output enable low, the port reads. With chip enable low, write select high and output enable high, the port neither reads, writes nor drives.
- R3: A read in cycle N raises that port's rdata_oe and presents the addressed word on its rdata during cycle N+1. In any other cycle, rdata_oe is low and rdata is zero.
- R4: In the cycle after a write, the writing port's rdata_oe is low.
- R5: A busy flag is raised only when both chip enables are low and the two addresses are equal. At most one of the two flags is high, and it goes to the losing port in the same cycle.
- R6: If both ports begin using the same address in the same cycle, the left port wins and the right busy flag is raised.
- R7: A port that was enabled on an address in the previous cycle and is still enabled on it keeps priority over a port that has just arrived, for as long as it stays there. While both ports stay on the address, the earlier winner keeps winning.
- R8: A write from a port whose effective busy is high does not change the array. The word holds the winner's data.
- R9: With ms_sel high (master), busy_oe is high, the internal arbiter decides which writes are dropped, and l_busy_in and r_busy_in have no effect.
- R10: With ms_sel low (slave), busy_oe is low. A port's write is dropped whenever its busy input is high, even when the ports do not collide. Reads are not affected by busy inputs.
- R11: If one port reads a word that the other port writes in the same cycle, the read returns the old value. A read of that word in the next cycle returns the new value.
- R12: While rst_n is low, both rdata_oe outputs are low and both rdata outputs are zero. They stay so after release until a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ms_sel | input | 1 | 1 = master (own arbiter), 0 = slave (external busy inputs) |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_we_n | input | 1 | Left write select, low = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | AW | Left word address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left read data, zero when not driven |
| l_rdata_oe | output | 1 | Left read-data drive enable |
| l_busy_in | input | 1 | Left busy from a master (used in slave mode) |
| l_busy_out | output | 1 | Left busy from the internal arbiter |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right write select, low = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | AW | Right word address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right read data, zero when not driven |
| r_rdata_oe | output | 1 | Right read-data drive enable |
| r_busy_in | input | 1 | Right busy from a master (used in slave mode) |
| r_busy_out | output | 1 | Right busy from the internal arbiter |
| busy_oe | output | 1 | Drive enable for the busy outputs (equals ms_sel) |

## Verification
The arbitration assertions assume that the control inputs and both addresses hold known values throughout each clock period, and that the first cycle after reset has a defined predecessor. They are therefore armed only from the second cycle after reset. The stimulus changes every input only on the falling clock edge and holds both ports idle while reset is low. It never drives an unknown value onto a control or an address. Read-back checks are made only on words that have already been written, so the unreset array contents never reach a compared output.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  // Decoded per-port operation for one clock cycle.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,   // chip enable inactive
    OP_READ  = 2'd1,   // enabled, write select high, output enable low
    OP_WRITE = 2'd2,   // enabled, write select low
    OP_QUIET = 2'd3    // enabled, write select high, output enable high
  } port_op_e;

  localparam int unsigned NPORT = 2;
  localparam int unsigned PL    = 0;
  localparam int unsigned PR    = 1;

endpackage

// File: rtl/dpram_port_ctl.sv
module dpram_port_ctl
  import dpram_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [DW-1:0] q,
  output port_op_e      op,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe
);

  logic vld_d;
  logic vld_q;

  // Control decode; output enable only matters when not writing.
  always_comb begin
    if (ce_n)       op = OP_IDLE;
    else if (!we_n) op = OP_WRITE;
    else if (!oe_n) op = OP_READ;
    else            op = OP_QUIET;
  end

  always_comb begin
    vld_d = (op == OP_READ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign rdata_oe = vld_q;
  assign rdata    = vld_q ? q : '0;

  AST_READ_DRIVES_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ) |=> rdata_oe);  // R3

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE) |=> !rdata_oe);  // R4

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE) |=> (!rdata_oe && rdata == '0));  // R2

endmodule

// File: rtl/dpram_arbiter.sv
module dpram_arbiter #(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    act,
  input  logic [AW-1:0] addr_l,
  input  logic [AW-1:0] addr_r,
  output logic [1:0]    busy
);

  logic [1:0]    prev_act_q;
  logic [AW-1:0] prev_addr_l_q;
  logic [AW-1:0] prev_addr_r_q;
  logic          win_r_q;
  logic          win_r_d;
  logic          match;
  logic          collide;
  logic          held_l;
  logic          held_r;
  logic          win_r;
  logic          armed_q;

  // Next-state: collision detect and priority choice.
  always_comb begin
    match   = (addr_l == addr_r);
    collide = act[0] && act[1] && match;
    held_l  = act[0] && prev_act_q[0] && (prev_addr_l_q == addr_l);
    held_r  = act[1] && prev_act_q[1] && (prev_addr_r_q == addr_r);
    if (held_l && held_r) win_r = win_r_q;
    else if (held_r)      win_r = 1'b1;
    else                  win_r = 1'b0;
    busy[0] = collide && win_r;
    busy[1] = collide && !win_r;
    win_r_d = collide ? win_r : win_r_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_act_q    <= '0;
      prev_addr_l_q <= '0;
      prev_addr_r_q <= '0;
      win_r_q       <= 1'b0;
      armed_q       <= 1'b0;
    end else begin
      prev_act_q <= act;
      if (act[0]) prev_addr_l_q <= addr_l;
      if (act[1]) prev_addr_r_q <= addr_r;
      if (collide) win_r_q <= win_r_d;
      armed_q <= 1'b1;
    end
  end

  AST_BUSY_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy));  // R5

  AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy != 2'b00) |-> (act == 2'b11 && addr_l == addr_r));  // R5

  AST_FRESH_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && act == 2'b11 && addr_l == addr_r
     && !($past(act[0]) && $past(addr_l) == addr_l)
     && !($past(act[1]) && $past(addr_r) == addr_r)) |-> (busy == 2'b10));  // R6

  AST_HOLDER_L_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && act == 2'b11 && addr_l == addr_r
     && $past(act[0]) && $past(addr_l) == addr_l
     && !($past(act[1]) && $past(addr_r) == addr_r)) |-> !busy[0]);  // R7

  AST_HOLDER_R_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && act == 2'b11 && addr_l == addr_r
     && $past(act[1]) && $past(addr_r) == addr_r
     && !($past(act[0]) && $past(addr_l) == addr_l)) |-> !busy[1]);  // R7

endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 12,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic [1:0]    wr_en,
  input  logic [1:0]    rd_en,
  input  logic [AW-1:0] addr_l,
  input  logic [AW-1:0] addr_r,
  input  logic [DW-1:0] wd_l,
  input  logic [DW-1:0] wd_r,
  output logic [DW-1:0] q_l,
  output logic [DW-1:0] q_r
);

  logic [DW-1:0] mem [DEPTH];

  // Both ports write in one process; arbitration keeps them apart.
  always_ff @(posedge clk) begin
    if (wr_en[0]) mem[addr_l] <= wd_l;
    if (wr_en[1]) mem[addr_r] <= wd_r;
  end

  // Registered reads sample the array before this edge's writes land.
  always_ff @(posedge clk) begin
    if (rd_en[0]) q_l <= mem[addr_l];
    if (rd_en[1]) q_r <= mem[addr_r];
  end

endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
  import dpram_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_sel,
  input  logic          l_ce_n,
  input  logic          l_we_n,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_rdata_oe,
  input  logic          l_busy_in,
  output logic          l_busy_out,
  input  logic          r_ce_n,
  input  logic          r_we_n,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_rdata_oe,
  input  logic          r_busy_in,
  output logic          r_busy_out,
  output logic          busy_oe
);

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic [NPORT-1:0] ce_n_v;
  logic [NPORT-1:0] we_n_v;
  logic [NPORT-1:0] oe_n_v;
  logic [NPORT-1:0] busy_ext;
  logic [NPORT-1:0] busy_int;
  logic [NPORT-1:0] busy_eff;
  logic [NPORT-1:0] act;
  logic [NPORT-1:0] wr_en;
  logic [NPORT-1:0] rd_en;
  logic [NPORT-1:0] oe_v;
  logic [DW-1:0]    q_v     [NPORT];
  logic [DW-1:0]    rdata_v [NPORT];
  port_op_e         op_v    [NPORT];

  // Reset asserts at once and releases two edges after rst_n rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign ce_n_v   = {r_ce_n, l_ce_n};
  assign we_n_v   = {r_we_n, l_we_n};
  assign oe_n_v   = {r_oe_n, l_oe_n};
  assign busy_ext = {r_busy_in, l_busy_in};
  assign busy_eff = ms_sel ? busy_int : busy_ext;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpram_port_ctl #(.DW(DW)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .ce_n     (ce_n_v[p]),
      .we_n     (we_n_v[p]),
      .oe_n     (oe_n_v[p]),
      .q        (q_v[p]),
      .op       (op_v[p]),
      .rdata    (rdata_v[p]),
      .rdata_oe (oe_v[p])
    );
    assign act[p]   = (op_v[p] != OP_IDLE);
    assign rd_en[p] = (op_v[p] == OP_READ);
    assign wr_en[p] = rst_sync_n && (op_v[p] == OP_WRITE) && !busy_eff[p];
  end

  dpram_arbiter #(.AW(AW)) u_arb (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .act    (act),
    .addr_l (l_addr),
    .addr_r (r_addr),
    .busy   (busy_int)
  );

  dpram_store #(.DW(DW), .AW(AW)) u_store (
    .clk    (clk),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr_l (l_addr),
    .addr_r (r_addr),
    .wd_l   (l_wdata),
    .wd_r   (r_wdata),
    .q_l    (q_v[PL]),
    .q_r    (q_v[PR])
  );

  assign l_rdata    = rdata_v[PL];
  assign r_rdata    = rdata_v[PR];
  assign l_rdata_oe = oe_v[PL];
  assign r_rdata_oe = oe_v[PR];
  assign l_busy_out = busy_int[PL];
  assign r_busy_out = busy_int[PR];
  assign busy_oe    = ms_sel;

  AST_NO_TWIN_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ms_sel |-> !(wr_en == 2'b11 && l_addr == r_addr));  // R8

  AST_SLAVE_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ms_sel && r_busy_in && busy_int[PR] == 1'b0) |-> !wr_en[PR]);  // R10

endmodule

// File: tb/tb_dpram_arb.sv
module tb_dpram_arb;

  localparam int unsigned DW = 9;
  localparam int unsigned AW = 12;

  // {ce_n, we_n, oe_n}
  localparam logic [2:0] C_IDLE = 3'b111;
  localparam logic [2:0] C_WR   = 3'b001;
  localparam logic [2:0] C_WRO  = 3'b000;
  localparam logic [2:0] C_RD   = 3'b010;
  localparam logic [2:0] C_QT   = 3'b011;
  localparam logic [2:0] C_PDW  = 3'b100;

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  lc;  logic [11:0] la; logic [8:0] ld;
    logic [2:0]  rc;  logic [11:0] ra; logic [8:0] rd;
    logic        ms;  logic lbi; logic rbi;
    logic        elb; logic erb;
    logic        elo; logic [8:0] elr;
    logic        ero; logic [8:0] err;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  C_WR,  12'h005, 9'h1A5, C_IDLE, 12'h000, 9'h000, 1'b1,1'b0,1'b0, 1'b0,1'b0, 1'b0,9'h000, 1'b0,9'h000}, // R1 write
    '{4'd2,  C_IDLE,12'h000, 9'h000, C_WRO,  12'h7FF, 9'h0C3, 1'b1,1'b0,1'b0, 1'b0,1'b0, 1'b0,9'h000, 1'b0,9'h000}, // R2 oe ignored on write, R4
    '{4'd3,  C_RD,  12'h005, 9'h000, C_RD,   12'h7FF, 9'h000, 1'b1,1'b0,1'b0, 1'b0,1'b0, 1'b1,9'h1A5, 1'b1,9'h0C3}, // R3 both read
    '{4'd2,  C_QT,  12'h005, 9'h000, C_PDW,  12'h005, 9'h0FF, 1'b1,1'b0,1'b0, 1'b0,1'b0, 1'b0,9'h000, 1'b0,9'h000}, // R2 quiet, disabled write
    '{4'd2,  C_RD,  12'h005, 9'h000, C_IDLE, 12'h000, 9'h000, 1'b1,1'b0,1'b0, 1'b0,1'b0, 1'b1,9'h1A5, 1'b0,9'h000}, // R2 word untouched
    '{4'd6,  C_WR,  12'h100, 9'h111, C_WR,   12'h100, 9'h0EE, 1'b1,1'b0,1'b0, 1'b0,1'b1, 1'b0,9'h000, 1'b0,9'h000}, // R6 tie
    '{4'd8,  C_IDLE,12'h000, 9'h000, C_RD,   12'h100, 9'h000, 1'b1,1'b0,1'b0, 1'b0,1'b0, 1'b0,9'h000, 1'b1,9'h111}, // R8 winner data
    '{4'd7,  C_WR,  12'h200, 9'h055, C_IDLE, 12'h000, 9'h000, 1'b1,1'b0,1'b0, 1'b0,1'b0, 1'b0,9'h000, 1'b0,9'h000}, // R7 left takes 200
    '{4'd7,  C_RD,  12'h200, 9'h000, C_WR,   12'h200, 9'h1FF, 1'b1,1'b0,1'b0, 1'b0,1'b1, 1'b1,9'h055, 1'b0,9'h000}, // R7 holder left
    '{4'd7,  C_RD,  12'h200, 9'h000, C_WR,   12'h200, 9'h1FF, 1'b1,1'b0,1'b0, 1'b0,1'b1, 1'b1,9'h055, 1'b0,9'h000}, // R7 both stay
    '{4'd7,  C_IDLE,12'h000, 9'h000, C_WR,   12'h200, 9'h1FF, 1'b1,1'b0,1'b0, 1'b0,1'b0, 1'b0,9'h000, 1'b0,9'h000}, // R7 holder left off
    '{4'd11, C_RD,  12'h200, 9'h000, C_WR,   12'h200, 9'h0AA, 1'b1,1'b0,1'b0, 1'b1,1'b0, 1'b1,9'h1FF, 1'b0,9'h000}, // R11 old value
    '{4'd11, C_RD,  12'h200, 9'h000, C_IDLE, 12'h000, 9'h000, 1'b1,1'b0,1'b0, 1'b0,1'b0, 1'b1,9'h0AA, 1'b0,9'h000}, // R11 new value
    '{4'd10, C_WR,  12'h300, 9'h033, C_IDLE, 12'h000, 9'h000, 1'b0,1'b0,1'b1, 1'b0,1'b0, 1'b0,9'h000, 1'b0,9'h000}, // R10 slave write
    '{4'd10, C_WR,  12'h300, 9'h144, C_IDLE, 12'h000, 9'h000, 1'b0,1'b1,1'b0, 1'b0,1'b0, 1'b0,9'h000, 1'b0,9'h000}, // R10 blocked
    '{4'd10, C_RD,  12'h300, 9'h000, C_IDLE, 12'h000, 9'h000, 1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b1,9'h033, 1'b0,9'h000}, // R10 check
    '{4'd9,  C_WR,  12'h301, 9'h0F0, C_IDLE, 12'h000, 9'h000, 1'b1,1'b1,1'b1, 1'b0,1'b0, 1'b0,9'h000, 1'b0,9'h000}, // R9 inputs ignored
    '{4'd9,  C_RD,  12'h301, 9'h000, C_RD,   12'h7FF, 9'h000, 1'b1,1'b1,1'b1, 1'b0,1'b0, 1'b1,9'h0F0, 1'b1,9'h0C3}, // R9 check
    '{4'd10, C_IDLE,12'h000, 9'h000, C_WR,   12'h7FF, 9'h000, 1'b0,1'b0,1'b1, 1'b0,1'b0, 1'b0,9'h000, 1'b0,9'h000}, // R10 right blocked
    '{4'd10, C_IDLE,12'h000, 9'h000, C_RD,   12'h7FF, 9'h000, 1'b0,1'b1,1'b1, 1'b0,1'b0, 1'b0,9'h000, 1'b1,9'h0C3}  // R10 read unaffected
  };

  logic          clk;
  logic          rst_n;
  logic          ms_sel;
  logic          l_ce_n, l_we_n, l_oe_n;
  logic [AW-1:0] l_addr;
  logic [DW-1:0] l_wdata;
  logic [DW-1:0] l_rdata;
  logic          l_rdata_oe;
  logic          l_busy_in, l_busy_out;
  logic          r_ce_n, r_we_n, r_oe_n;
  logic [AW-1:0] r_addr;
  logic [DW-1:0] r_wdata;
  logic [DW-1:0] r_rdata;
  logic          r_rdata_oe;
  logic          r_busy_in, r_busy_out;
  logic          busy_oe;

  int n_chk;
  int n_bad;
  bit done;

  dpram_arb #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ms_sel(ms_sel),
    .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rdata_oe(l_rdata_oe),
    .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
    .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rdata_oe(r_rdata_oe),
    .r_busy_in(r_busy_in), .r_busy_out(r_busy_out),
    .busy_oe(busy_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input string what, input int req, input logic [8:0] got,
                       input logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle_all();
    {l_ce_n, l_we_n, l_oe_n} = C_IDLE;
    {r_ce_n, r_we_n, r_oe_n} = C_IDLE;
    l_addr = '0; r_addr = '0; l_wdata = '0; r_wdata = '0;
    l_busy_in = 1'b0; r_busy_in = 1'b0;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; ms_sel = 1'b1;
    idle_all();
    repeat (3) @(negedge clk);
    // R12: outputs quiet in reset
    check("rdata_oe L in reset", 12, {8'd0, l_rdata_oe}, 9'd0);
    check("rdata L in reset", 12, l_rdata, 9'd0);
    check("rdata_oe R in reset", 12, {8'd0, r_rdata_oe}, 9'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("rdata_oe L after reset", 12, {8'd0, l_rdata_oe}, 9'd0);
    check("busy pair after reset", 12, {7'd0, l_busy_out, r_busy_out}, 9'd0);
    check("busy_oe master", 9, {8'd0, busy_oe}, 9'd1);

    for (int i = 0; i < NV; i++) begin
      {l_ce_n, l_we_n, l_oe_n} = VEC[i].lc;
      l_addr = VEC[i].la; l_wdata = VEC[i].ld;
      {r_ce_n, r_we_n, r_oe_n} = VEC[i].rc;
      r_addr = VEC[i].ra; r_wdata = VEC[i].rd;
      ms_sel = VEC[i].ms; l_busy_in = VEC[i].lbi; r_busy_in = VEC[i].rbi;
      #5;
      check($sformatf("vec %0d l_busy_out", i), VEC[i].req, {8'd0, l_busy_out}, {8'd0, VEC[i].elb});
      check($sformatf("vec %0d r_busy_out", i), VEC[i].req, {8'd0, r_busy_out}, {8'd0, VEC[i].erb});
      check($sformatf("vec %0d busy_oe", i), VEC[i].req, {8'd0, busy_oe}, {8'd0, VEC[i].ms});
      @(posedge clk);
      #5;
      check($sformatf("vec %0d l_rdata_oe", i), VEC[i].req, {8'd0, l_rdata_oe}, {8'd0, VEC[i].elo});
      check($sformatf("vec %0d l_rdata", i), VEC[i].req, l_rdata, VEC[i].elr);
      check($sformatf("vec %0d r_rdata_oe", i), VEC[i].req, {8'd0, r_rdata_oe}, {8'd0, VEC[i].ero});
      check($sformatf("vec %0d r_rdata", i), VEC[i].req, r_rdata, VEC[i].err);
      @(negedge clk);
    end

    // R7 directed: right holds, left arrives, right keeps winning while both stay
    idle_all(); ms_sel = 1'b1;
    {r_ce_n, r_we_n, r_oe_n} = C_RD; r_addr = 12'h005;
    @(negedge clk);
    {l_ce_n, l_we_n, l_oe_n} = C_WR; l_addr = 12'h005; l_wdata = 9'h0DD;
    #5;
    check("held right, left busy", 7, {7'd0, l_busy_out, r_busy_out}, 9'b10);
    @(negedge clk);
    #5;
    check("both stay, left still busy", 7, {7'd0, l_busy_out, r_busy_out}, 9'b10);
    @(negedge clk);
    idle_all();
    {l_ce_n, l_we_n, l_oe_n} = C_RD; l_addr = 12'h005;
    @(posedge clk); #5;
    check("blocked left write left word intact", 8, l_rdata, 9'h1A5);
    @(negedge clk);

    // R12 directed: reset during a read drops the drive at once
    idle_all();
    {l_ce_n, l_we_n, l_oe_n} = C_RD; l_addr = 12'h005;
    @(posedge clk); #5;
    check("read before reset", 3, {8'd0, l_rdata_oe}, 9'd1);
    rst_n = 1'b0;
    #1;
    check("rdata_oe at reset", 12, {8'd0, l_rdata_oe}, 9'd0);
    check("rdata at reset", 12, l_rdata, 9'd0);
    @(negedge clk);
    idle_all();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule